// File: doc/BRIEF.md
# GPIO Input Change Interrupt Generator

This block raises an interrupt request for a small general-purpose I/O port whenever a pin used as an input moves away from a stored reference level. The reference is the set of pin levels taken when software last read the port's input register. The block receives the raw pin levels and passes them through a synchronizer of its own. It also receives the direction bits from the port's configuration register and a one-cycle pulse that marks a completed input-register read. It drives one enable, `irq_pull_o`, which the pad ring uses as an open-drain pull on the active-low interrupt line. When the enable is 1 the line is pulled low. When it is 0 the line is released and floats high through the board pull-up.

The request clears in two ways. A read clears it and also captures new reference levels. It also clears with no read when every input that had changed goes back to its reference level. Pins set as outputs are masked out. If a pin is switched from output to input while its level differs from the reference, a request is raised. This is intended behaviour.

None of the interfaces carries a data stream, so they are plain level and pulse signals with no handshake. The read pulse is never back-pressured.

Top module: `gpio_irq_gen`

## Requirements
- R1: While reset is asserted, `irq_pull_o` is 0. After reset is released, the reference register loads the synchronized pin levels before the comparison is armed. As a result, no request appears at start-up, whatever the pins are at that time.
- R2: A direction bit of 1 marks its pin as an input. If an input pin's level changes to differ from its reference, `irq_pull_o` goes to 1 on the third rising clock edge after the change: two edges for the synchronizer and one for the output register. This is far within 4 us at any practical clock.
- R3: A `rd_done_i` pulse seen on a clock edge forces `irq_pull_o` to 0 on that same edge. On that edge the synchronized pin levels also become the new reference. A later return to the old levels therefore raises a request.
- R4: With no read, `irq_pull_o` stays 1 while any input pin still differs from its reference. It returns to 0 on the third edge after the last differing input comes back to its reference level.
- R5: A pin whose direction bit is 0 (output) never contributes to `irq_pull_o`, however its level moves.
- R6: Changing a direction bit from 0 to 1 on a pin whose synchronized level differs from its reference sets `irq_pull_o` on the next clock edge.
- R7: A read takes priority over a change reaching the comparator on the same edge. `irq_pull_o` stays 0, and because the changed level becomes the reference, no request follows.
- R8: Reset is asynchronous. Asserting `rst_n` low drops a pending `irq_pull_o` at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | WIDTH | Raw pin levels, asynchronous to `clk` |
| dir_in_i | input | WIDTH | Direction bits from the configuration register; 1 = input, 0 = output |
| rd_done_i | input | 1 | One-cycle pulse: input register has just been read |
| irq_pull_o | output | 1 | Open-drain enable; 1 pulls the active-low interrupt line low, 0 releases it |

## Verification
A pin change reaches `irq_pull_o` on the third edge after it is driven. A direction change reaches it on the next edge. A read pulse clears it on the edge that samples the pulse. After reset release the output is held at 0 through the warm-up edges. The scoreboard stamps each expectation with the exact cycle number at which the result is due. For pin changes it also stamps the cycle one before that, expecting the old value, so a result that arrives early or late is caught. Every comparison happens on the falling edge, half a cycle away from the edges that move the result. Expectations that fall in the current cycle are compared on the spot.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned IRQ_DEF_WIDTH = 4;
  localparam int unsigned IRQ_DEF_SYNC  = 2;
  localparam logic        DIR_INPUT     = 1'b1;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_ref.sv
module gpio_irq_ref #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  input  logic             rd_done_i,
  output logic [WIDTH-1:0] ref_o,
  output logic             armed_o
);
  // Warm-up: synchronizer needs STAGES edges, then one edge to capture.
  localparam int unsigned WARM = STAGES + 1;
  localparam int unsigned CW   = $clog2(WARM + 1);

  logic [CW-1:0]    warm_q;
  logic [WIDTH-1:0] ref_q;

  assign armed_o = (warm_q == CW'(WARM));
  assign ref_o   = ref_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
      ref_q  <= '0;
    end else if (!armed_o) begin
      warm_q <= warm_q + CW'(1);
      ref_q  <= level_i;
    end else if (rd_done_i) begin
      ref_q  <= level_i;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_i,
  input  logic [WIDTH-1:0] ref_i,
  input  logic [WIDTH-1:0] dir_in_i,
  input  logic             rd_done_i,
  input  logic             armed_i,
  output logic             pull_o
);
  logic [WIDTH-1:0] live_mask;
  logic             pull_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign live_mask[b] = (level_i[b] ^ ref_i[b]) & (dir_in_i[b] == DIR_INPUT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     pull_q <= 1'b0;
    else if (!armed_i || rd_done_i) pull_q <= 1'b0;
    else                            pull_q <= |live_mask;
  end

  assign pull_o = pull_q;
endmodule

// File: rtl/gpio_irq_gen.sv
module gpio_irq_gen
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH       = IRQ_DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = IRQ_DEF_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pin_i,
  input  logic [WIDTH-1:0] dir_in_i,
  input  logic             rd_done_i,
  output logic             irq_pull_o
);
  logic [WIDTH-1:0] level_q;
  logic [WIDTH-1:0] ref_q;
  logic             armed;

  gpio_irq_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(level_q)
  );

  gpio_irq_ref #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_ref (
    .clk(clk), .rst_n(rst_n), .level_i(level_q), .rd_done_i(rd_done_i),
    .ref_o(ref_q), .armed_o(armed)
  );

  gpio_irq_detect #(.WIDTH(WIDTH)) u_det (
    .clk(clk), .rst_n(rst_n), .level_i(level_q), .ref_i(ref_q),
    .dir_in_i(dir_in_i), .rd_done_i(rd_done_i), .armed_i(armed),
    .pull_o(irq_pull_o)
  );
endmodule

// File: rtl/gpio_irq_gen_chk.sv
module gpio_irq_gen_chk #(
  parameter int unsigned WIDTH       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] dir_in_i,
  input logic             rd_done_i,
  input logic             irq_pull_o,
  input logic [WIDTH-1:0] ref_q,
  input logic             armed
);
  localparam int unsigned CW = $clog2(SYNC_STAGES + 3);
  logic [CW-1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != CW'(SYNC_STAGES + 2)) since_rst <= since_rst + CW'(1);
  end

  // R1: quiet through the warm-up edges after reset release
  p_startup_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst <= CW'(SYNC_STAGES)) |-> !irq_pull_o);

  // R3: a read pulse clears the request on the sampling edge
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done_i |=> !irq_pull_o);

  // R3: reference changes only on a read once armed
  p_ref_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !rd_done_i) |=> $stable(ref_q));

  // R5: with every pin an output, no request follows
  p_output_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_in_i == '0) |=> !irq_pull_o);

  // R7: a request never rises on an edge that sampled a read
  p_rise_no_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pull_o) |-> !$past(rd_done_i));
endmodule

bind gpio_irq_gen gpio_irq_gen_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .dir_in_i(dir_in_i), .rd_done_i(rd_done_i),
  .irq_pull_o(irq_pull_o), .ref_q(ref_q), .armed(armed)
);

// File: tb/gpio_irq_gen_test.sv
module gpio_irq_gen_test;
  typedef struct {
    int    cyc;
    logic  val;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] pins = 4'b0101;
  logic [3:0] dir = 4'b1111;
  logic       rd = 1'b0;
  logic       irq;
  int         cyc = 0;
  int         n_cmp = 0;
  int         n_bad = 0;
  exp_t       q[$];

  gpio_irq_gen uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .dir_in_i(dir),
    .rd_done_i(rd), .irq_pull_o(irq)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic cmp(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s cycle %0d: actual=%b expected=%b", tag, cyc, act, exp);
    end
  endtask

  task automatic expect_at(input int c, input logic v, input string tag);
    exp_t e;
    e.cyc = c; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares due expectations half a cycle from the active edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      e = q.pop_front();
      if (e.cyc < cyc) begin
        n_cmp++; n_bad++;
        $display("FAIL %s missed: actual=none expected=%b at cycle %0d", e.tag, e.val, e.cyc);
      end else cmp(irq, e.val, e.tag);
    end
  end

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic set_pins(input logic [3:0] v, input logic after2, input logic after3,
                          input string tag);
    @(negedge clk);
    pins = v;
    expect_at(cyc + 2, after2, tag);
    expect_at(cyc + 3, after3, tag);
  endtask

  task automatic read_pulse(input logic now_val, input string tag);
    @(negedge clk);
    rd = 1'b1;
    cmp(irq, now_val, tag);
    expect_at(cyc + 1, 1'b0, tag);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=hung expected=done");
    finish_run();
  end

  initial begin
    // R1: idle in reset, and quiet after release with nonzero pins
    repeat (3) @(negedge clk);
    cmp(irq, 1'b0, "R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 1; i <= 6; i++) expect_at(cyc + i, 1'b0, "R1 start-up");
    drain();

    // R2: pin0 falls, request on third edge
    set_pins(4'b0100, 1'b0, 1'b1, "R2 assert latency");
    drain();
    // R4: pin0 returns, request clears on third edge
    set_pins(4'b0101, 1'b1, 1'b0, "R4 self clear");
    drain();

    // R4: two pins differ, one returns -> held; both return -> cleared
    set_pins(4'b0110, 1'b0, 1'b1, "R4 two pins");
    drain();
    set_pins(4'b0111, 1'b1, 1'b1, "R4 one still differs");
    expect_at(cyc + 5, 1'b1, "R4 one still differs");
    drain();
    set_pins(4'b0101, 1'b1, 1'b0, "R4 all returned");
    drain();

    // R3: read clears and recaptures reference
    set_pins(4'b1101, 1'b0, 1'b1, "R3 raise");
    drain();
    read_pulse(1'b1, "R3 read clear");
    expect_at(cyc + 3, 1'b0, "R3 stays clear");
    drain();
    set_pins(4'b0101, 1'b0, 1'b1, "R3 old level vs new reference");
    drain();
    read_pulse(1'b1, "R3 read clear 2");
    drain();

    // R5: pin0 as output, toggling it never raises
    @(negedge clk);
    dir = 4'b1110;
    set_pins(4'b0100, 1'b0, 1'b0, "R5 output masked");
    expect_at(cyc + 6, 1'b0, "R5 output masked");
    drain();

    // R6: switch pin0 back to input while it differs from reference
    @(negedge clk);
    dir = 4'b1111;
    cmp(irq, 1'b0, "R6 before switch");
    expect_at(cyc + 1, 1'b1, "R6 switch raises");
    drain();
    read_pulse(1'b1, "R6 read clear");
    drain();

    // R7: read lands on the edge the change reaches the output
    @(negedge clk);
    pins = 4'b0110;
    expect_at(cyc + 3, 1'b0, "R7 read priority");
    expect_at(cyc + 4, 1'b0, "R7 read priority");
    expect_at(cyc + 7, 1'b0, "R7 change absorbed");
    @(negedge clk);
    @(negedge clk);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    drain();

    // R8: asynchronous reset drops a pending request at once
    set_pins(4'b0111, 1'b0, 1'b1, "R8 raise");
    drain();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    cmp(irq, 1'b0, "R8 async reset");
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 1; i <= 5; i++) expect_at(cyc + i, 1'b0, "R1 restart quiet");
    drain();

    finish_run();
  end
endmodule